// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 12-bit successive-approximation converter with a three-wire serial port. A one-cycle `start` pulse makes it pull the active-low chip select low and run a serial clock made by dividing the system clock. It lets the converter's sampling clocks and its leading LOW null bit go by, then takes in the conversion word MSB first. Each bit is captured on a rising serial-clock edge, because the converter launches data on falling edges.

In check mode the controller keeps clocking after the last bit of the word. The converter then sends the word again, LSB first. The controller captures those eleven repeated bits and compares them with the word it already holds. The word appears on `res_data` with a one-cycle `res_valid` strobe, and `res_mismatch` and `res_null_err` report on the same cycle. Chip select is then held high for a guard interval, which limits throughput. There is no back-pressure on the result: the consumer must take it on the strobe cycle, and the result stays on `res_data` until the next strobe. `busy` blocks new requests until the guard interval has passed.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, or after reset is applied in the middle of a frame, `cs_n`=1, `sclk`=0, `busy`=0, `res_valid`=0.
- R2: A `start` pulse seen at a clock edge while `busy`=0 drives `cs_n` low and `busy` high from that same edge.
- R3: While `cs_n` is low, `sclk` has a period of CLK_DIV system clocks and begins with a low half. Whenever `cs_n` is high, `sclk` is 0. A frame has 15 rising `sclk` edges in normal mode and 26 in check mode.
- R4: `sdo` is sampled at the rising `sclk` edges. Rise 3 carries the null bit. Rises 4 to 15 carry word bits 11 down to 0, and the word is presented on `res_data`.
- R5: `res_null_err` is 1 with the strobe exactly when the null bit was sampled as 1.
- R6: In check mode, rises 16 to 26 carry word bits 1 to 11 in that order. `res_mismatch` is 1 exactly when any of them differs from the matching bit of the word.
- R7: In normal mode the frame stops after rise 15 and `res_mismatch` is 0.
- R8: `res_valid` is a one-cycle pulse on the first cycle with `cs_n` high. It comes (2N-1)*CLK_DIV/2+1 clock edges after the start edge, where N is the number of rises.
- R9: `cs_n` stays high for at least IDLE_CYC cycles before it falls again. `busy` falls IDLE_CYC edges after the strobe.
- R10: A `start` pulse seen while `busy`=1, whether during the transfer or during the guard interval, has no effect.
- R11: `chk_mode` is sampled only with an accepted `start`. Changing it during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| chk_mode | input | 1 | 1: also capture and compare the LSB-first repeat |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Request in progress, including the guard interval |
| res_data | output | 12 | Conversion word |
| res_valid | output | 1 | One-cycle strobe for the result |
| res_mismatch | output | 1 | Repeat bits disagreed with the word |
| res_null_err | output | 1 | Null bit was not LOW |

## Verification
The assertions make no assumption about when `start` arrives. They expect it to be dropped while `busy` is high, and the stimulus deliberately pulses it during both the transfer and the guard interval. They also take for granted that `sdo` changes only after falling `sclk` edges and never close to a rising one. The bench's converter model guarantees this, because it updates `sdo` only from a count of `sclk` falls. The model also flips the null bit and one repeat bit on request, to produce the error flags.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FIN   = 2'd2,
    ST_GUARD = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_sclk_div.sv
// Divides clk by an even ratio. The output starts low when enabled and is
// forced low when disabled. rise flags the cycle that ends with a 0->1 edge.
module adc_sclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          sclk_q;

  assign sclk = sclk_q;
  assign rise = en && !sclk_q && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
// Frame sequencer: chip select, rise counting, guard interval, busy.
module adc_frame_ctrl
  import adc_rd_pkg::*;
#(
  parameter int IDLE_CYC = 16,
  parameter int LAST_STD = 15,
  parameter int LAST_CHK = 26,
  parameter int RW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          chk_mode,
  input  logic          rise,
  output logic          run,
  output logic          fin,
  output logic          chk_q,
  output logic [RW-1:0] rcnt,
  output logic          cs_n,
  output logic          busy
);
  localparam int GW = $clog2(IDLE_CYC + 1);

  rd_state_e     state;
  logic [GW-1:0] gcnt;
  logic [RW-1:0] last_rise;

  assign run       = (state == ST_RUN);
  assign fin       = (state == ST_FIN);
  assign last_rise = chk_q ? RW'(LAST_CHK) : RW'(LAST_STD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      gcnt  <= '0;
      rcnt  <= '0;
      chk_q <= 1'b0;
      cs_n  <= 1'b1;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cs_n  <= 1'b0;
            busy  <= 1'b1;
            chk_q <= chk_mode;
            rcnt  <= '0;
          end
        end
        ST_RUN: begin
          if (rise) begin
            rcnt <= rcnt + RW'(1);
            if (rcnt + RW'(1) == last_rise) state <= ST_FIN;
          end
        end
        ST_FIN: begin
          cs_n  <= 1'b1;
          gcnt  <= '0;
          state <= ST_GUARD;
        end
        default: begin
          if (gcnt == GW'(IDLE_CYC - 1)) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_bit_capture.sv
// Routes sampled bits by rise number into the null flag, the MSB-first word
// and the repeat register, then publishes the result on fin.
module adc_bit_capture #(
  parameter int DATA_W   = 12,
  parameter int NULL_POS = 3,
  parameter int RW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic [RW-1:0]     rcnt,
  input  logic              sdo,
  input  logic              fin,
  input  logic              chk_q,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              res_mismatch,
  output logic              res_null_err
);
  localparam int WORD_LO = NULL_POS + 1;
  localparam int WORD_HI = NULL_POS + DATA_W;
  localparam int REP_LO  = WORD_HI + 1;
  localparam int REP_HI  = WORD_HI + DATA_W - 1;

  logic [RW-1:0]     n;
  logic [DATA_W-1:0] word;
  logic [DATA_W-2:0] rep;
  logic              null_q;
  logic              in_word;
  logic              in_rep;

  assign n       = rcnt + RW'(1);
  assign in_word = (n >= RW'(WORD_LO)) && (n <= RW'(WORD_HI));
  assign in_rep  = (n >= RW'(REP_LO)) && (n <= RW'(REP_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      rep    <= '0;
      null_q <= 1'b0;
    end else if (rise) begin
      if (n == RW'(NULL_POS)) null_q <= sdo;
      if (in_word) word <= {word[DATA_W-2:0], sdo};
      // repeat arrives low bit first: shifting right lines bit k up at rep[k-1]
      if (in_rep) rep <= {sdo, rep[DATA_W-2:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data     <= '0;
      res_valid    <= 1'b0;
      res_mismatch <= 1'b0;
      res_null_err <= 1'b0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        res_data     <= word;
        res_mismatch <= chk_q && (rep != word[DATA_W-1:1]);
        res_null_err <= null_q;
      end
    end
  end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DATA_W     = 12,
  parameter int CLK_DIV    = 4,
  parameter int IDLE_CYC   = 16,
  parameter int SKIP_RISES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chk_mode,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              res_mismatch,
  output logic              res_null_err
);
  localparam int NULL_POS = SKIP_RISES + 1;
  localparam int LAST_STD = NULL_POS + DATA_W;
  localparam int LAST_CHK = LAST_STD + DATA_W - 1;
  localparam int RW       = $clog2(LAST_CHK + 1);

  logic          run;
  logic          fin;
  logic          rise;
  logic          chk_q;
  logic [RW-1:0] rcnt;

  adc_sclk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(run), .sclk(sclk), .rise(rise)
  );

  adc_frame_ctrl #(
    .IDLE_CYC(IDLE_CYC), .LAST_STD(LAST_STD), .LAST_CHK(LAST_CHK), .RW(RW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_mode(chk_mode),
    .rise(rise), .run(run), .fin(fin), .chk_q(chk_q), .rcnt(rcnt),
    .cs_n(cs_n), .busy(busy)
  );

  adc_bit_capture #(.DATA_W(DATA_W), .NULL_POS(NULL_POS), .RW(RW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rise(rise), .rcnt(rcnt), .sdo(sdo),
    .fin(fin), .chk_q(chk_q), .res_data(res_data), .res_valid(res_valid),
    .res_mismatch(res_mismatch), .res_null_err(res_null_err)
  );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int IDLE_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic res_valid
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= 16'hFFFF;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8
  valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |-> (hi_cnt >= 16'(IDLE_CYC)));

  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy)));
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.IDLE_CYC(IDLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cs_n(cs_n),
  .sclk(sclk), .res_valid(res_valid)
);

// File: tb/sim_adc_serial_reader.sv
module sim_adc_serial_reader;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic chk_mode = 1'b0;
  logic sdo;
  logic cs_n, sclk, busy, res_valid, res_mismatch, res_null_err;
  logic [11:0] res_data;

  int checks = 0;
  int failures = 0;

  // converter model state
  logic [11:0] m_word = '0;
  logic        m_frep = 1'b0;
  logic        m_fnull = 1'b0;
  int          fcnt = 0;

  always #5 clk = ~clk;

  adc_serial_reader #(.DATA_W(12), .CLK_DIV(DIV), .IDLE_CYC(IDLE), .SKIP_RISES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chk_mode(chk_mode), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .res_data(res_data),
    .res_valid(res_valid), .res_mismatch(res_mismatch), .res_null_err(res_null_err)
  );

  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) fcnt = 0;
    else fcnt = fcnt + 1;
  end

  function automatic logic model_bit(int f, logic [11:0] w, logic fr, logic fn);
    if (f == 2) return fn;
    if (f >= 3 && f <= 14) return w[14-f];
    if (f >= 15 && f <= 25) return w[f-14] ^ (fr && f == 20);
    return 1'b1;
  endfunction

  assign sdo = model_bit(fcnt, m_word, m_frep, m_fnull);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [11:0] w, input logic c, input logic fr,
                           input logic fn, input bit mid_poke, input bit guard_poke);
    int n, cyc, rises, highs, g;
    logic prev;
    n = c ? 26 : 15;
    m_word = w; m_frep = fr; m_fnull = fn;
    @(negedge clk);
    start = 1'b1; chk_mode = c;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk_mode = ~c;  // R11: flipping the mode mid-frame must not matter
    check(!cs_n && busy, "R2 cs_n/busy after start", {cs_n, busy}, 2'b01);
    cyc = 0; rises = 0; highs = 0; prev = 1'b0;
    while (!res_valid && cyc < 1000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = mid_poke && (cyc == 20);
      if (sclk && !prev) rises++;
      if (sclk) highs++;
      prev = sclk;
    end
    start = 1'b0;
    check(res_data == w, "R4 res_data", res_data, w);
    check(res_null_err == fn, "R5 null_err", res_null_err, fn);
    check(res_mismatch == (c & fr), c ? "R6 mismatch" : "R7 mismatch",
          res_mismatch, c & fr);
    check(rises == n, "R3 rise count", rises, n);
    check(highs == (n - 1) * HALF + 1, "R3 sclk high cycles", highs, (n - 1) * HALF + 1);
    check(cyc == (2 * n - 1) * HALF + 1, "R8 latency", cyc, (2 * n - 1) * HALF + 1);
    check(cs_n == 1'b1, "R8 cs_n high at strobe", cs_n, 1);
    g = 0;
    while (busy && g < 1000) begin
      @(posedge clk);
      g++;
      @(negedge clk);
      start = guard_poke && (g == 3);
      if (res_valid || !cs_n || sclk) begin
        check(1'b0, "R9 guard quiet", {res_valid, cs_n, sclk}, 3'b010);
      end
    end
    start = 1'b0;
    check(g == IDLE, "R9 busy release", g, IDLE);
    if (mid_poke || guard_poke) begin
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (!cs_n || busy) check(1'b0, "R10 poke ignored", {cs_n, busy}, 2'b10);
      end
      check(cs_n && !busy, "R10 idle after poke", {cs_n, busy}, 2'b10);
    end
  endtask

  localparam int NV = 8;
  // {word[11:0], chk, flip_repeat, flip_null}
  localparam logic [14:0] VEC [NV] = '{
    {12'hA5C, 1'b1, 1'b0, 1'b0},
    {12'h000, 1'b0, 1'b0, 1'b0},
    {12'hFFF, 1'b1, 1'b0, 1'b0},
    {12'h800, 1'b0, 1'b0, 1'b1},
    {12'h7FF, 1'b1, 1'b1, 1'b0},
    {12'h3C3, 1'b0, 1'b1, 1'b0},
    {12'h001, 1'b1, 1'b0, 1'b1},
    {12'h5A5, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n && !sclk && !busy && !res_valid, "R1 reset outputs",
          {cs_n, sclk, busy, res_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 2'b10);

    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i][14:3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, 1'b0);
    end

    // R10: start during transfer, then during guard
    run_frame(12'h9B4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_frame(12'h26D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a frame
    @(negedge clk);
    start = 1'b1; chk_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !busy && !res_valid, "R1 mid-frame reset",
          {cs_n, sclk, busy, res_valid}, 4'b1000);
    rst_n = 1'b1;
    repeat (IDLE + 2) @(negedge clk);
    run_frame(12'hC3A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule